// File: doc/BRIEF.md
# Hash Engine Command Front-End

This block is the register front-end of a hash accelerator. Software programs a data source address, a state/digest address, a keyed-hash key address and a byte length through 32-bit register writes. A write to the command register then launches one job. The command word carries the algorithm choice, an accumulate flag and a byte-order flag. The block decodes these fields and holds them steady for the downstream engine. It issues a one-cycle start pulse, tracks busy until the engine reports done, and then raises a completion interrupt that software clears by writing a one to it.

Commands are guarded. A command written while a job is running is dropped and recorded in a sticky error bit. A command whose algorithm field matches none of the four legal patterns is also dropped, and it sets a second sticky error bit. An overflow indication from the engine is latched into a sticky status bit.

Top module: `hash_cmd_front`

## Requirements
- R1: After reset, busy, the interrupt, both error bits, the overflow bit and start_o are 0. Every address, length and command register reads 0.
- R2: Writes to offset 0x20 (source), 0x24 (digest), 0x28 (key) and 0x2C (length) are stored. Each value reads back at its offset and drives its matching output port.
- R3: A command write at offset 0x30 while idle, with a legal algorithm, produces a one-cycle start_o pulse in the cycle after the write. Status bit 0 (busy) is 1 from that same cycle on. The accepted word reads back at 0x30.
- R4: The algorithm is decoded from command bits {10,6,5,4} with all other bits ignored. The legal patterns are 0010, which gives algo_o=0 (SHA-1); 0101, which gives algo_o=1 (SHA-256); 1110, which gives algo_o=2 (SHA-384); and 0110, which gives algo_o=3 (SHA-512). Command bit 8 drives accum_o and bit 3 drives big_endian_o. All three outputs update only on an accepted command.
- R5: A command write while idle with any other algorithm pattern gives no start pulse, leaves busy at 0, sets sticky status bit 2 and leaves the 0x30 readback unchanged.
- R6: A command write while busy is ignored. It gives no start pulse, leaves the decoded outputs and the 0x30 readback unchanged, and sets sticky status bit 1.
- R7: When engine_done_i is high while busy, busy falls and status bit 9 (the interrupt, also on irq_o) rises in the same cycle. engine_done_i while idle has no effect.
- R8: A status write at 0x1C clears each of bits 1, 2, 9 and 23 whose write-data bit is 1 and leaves the others. Busy cannot be written.
- R9: engine_ovf_i high for a cycle sets sticky status bit 23 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| engine_done_i | input | 1 | Engine has finished the current job |
| engine_ovf_i | input | 1 | Engine reports data overflow |
| start_o | output | 1 | One-cycle job launch pulse |
| algo_o | output | 2 | Decoded algorithm select |
| accum_o | output | 1 | Accumulate mode |
| big_endian_o | output | 1 | Big-endian data handling |
| src_addr_o | output | 32 | Data source address |
| digest_addr_o | output | 32 | Digest/state address |
| key_addr_o | output | 32 | Key address |
| length_o | output | 32 | Data length |
| irq_o | output | 1 | Completion interrupt |

## Verification
On every cycle, the assertions check four things. A start pulse only ever follows an idle cycle and a legal algorithm pattern. Busy only rises together with a start pulse. The interrupt is set whenever busy falls. Overflow stays sticky unless it is cleared. The bench sweeps all sixteen patterns of the algorithm bits with varying flag and noise bits. This sweep is what shows the decode table, the rejection of illegal codes, the readback of accepted words and the write-one-to-clear behaviour at the ports. Dropped commands while busy, done while idle, and the unwritable busy bit also appear only in the bench scenarios.

// File: rtl/hash_fe_pkg.sv
package hash_fe_pkg;
  typedef enum logic [1:0] {
    ALG_SHA1   = 2'd0,
    ALG_SHA256 = 2'd1,
    ALG_SHA384 = 2'd2,
    ALG_SHA512 = 2'd3
  } algo_e;

  localparam int unsigned OFS_STATUS = 'h1C;
  localparam int unsigned OFS_SRC    = 'h20;
  localparam int unsigned OFS_CMD    = 'h30;
  localparam int unsigned NUM_PTRS   = 4;

  localparam int unsigned ST_BUSY    = 0;
  localparam int unsigned ST_EBUSY   = 1;
  localparam int unsigned ST_EALGO   = 2;
  localparam int unsigned ST_IRQ     = 9;
  localparam int unsigned ST_OVF     = 23;

  localparam int unsigned CMD_BE     = 3;
  localparam int unsigned CMD_ACCUM  = 8;
endpackage

// File: rtl/hash_fe_decode.sv
module hash_fe_decode
  import hash_fe_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] cmd_i,
  output algo_e         algo_o,
  output logic          legal_o
);
  logic [3:0] sel;
  assign sel = {cmd_i[10], cmd_i[6], cmd_i[5], cmd_i[4]};

  always_comb begin
    legal_o = 1'b1;
    algo_o  = ALG_SHA1;
    unique case (sel)
      4'b0010: algo_o = ALG_SHA1;
      4'b0101: algo_o = ALG_SHA256;
      4'b1110: algo_o = ALG_SHA384;
      4'b0110: algo_o = ALG_SHA512;
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hash_fe_ptrs.sv
module hash_fe_ptrs
  import hash_fe_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [NUM_PTRS-1:0]     hit_o,
  output logic [NUM_PTRS*DW-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_reg
    logic [DW-1:0] q;
    assign hit_o[g] = (addr_i == AW'(OFS_SRC + 4 * g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q <= '0;
      else if (wr_en_i && hit_o[g]) q <= wdata_i;
    end
    assign regs_o[g*DW +: DW] = q;
  end
endmodule

// File: rtl/hash_fe_ctrl.sv
module hash_fe_ctrl
  import hash_fe_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic          legal_i,
  input  logic          st_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  input  logic          ovf_i,
  output logic          accept_o,
  output logic          start_o,
  output logic [DW-1:0] status_o
);
  logic busy_q, ebusy_q, ealgo_q, irq_q, ovf_q;
  logic [DW-1:0] clr;

  assign clr      = st_wr_i ? wdata_i : '0;
  assign accept_o = cmd_wr_i && !busy_q && legal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_o <= 1'b0;
      ebusy_q <= 1'b0;
      ealgo_q <= 1'b0;
      irq_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      start_o <= accept_o;
      // clears first, sets override
      ebusy_q <= (ebusy_q && !clr[ST_EBUSY]) || (cmd_wr_i && busy_q);
      ealgo_q <= (ealgo_q && !clr[ST_EALGO]) || (cmd_wr_i && !busy_q && !legal_i);
      ovf_q   <= (ovf_q && !clr[ST_OVF]) || ovf_i;
      irq_q   <= (irq_q && !clr[ST_IRQ]) || (busy_q && done_i);
      if (accept_o)               busy_q <= 1'b1;
      else if (busy_q && done_i)  busy_q <= 1'b0;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_BUSY]  = busy_q;
    status_o[ST_EBUSY] = ebusy_q;
    status_o[ST_EALGO] = ealgo_q;
    status_o[ST_IRQ]   = irq_q;
    status_o[ST_OVF]   = ovf_q;
  end

  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_q));
  p_busy_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> start_o);
  p_irq_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> irq_q);
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovf_i) || ($past(ovf_q) && !$past(clr[ST_OVF]))) |-> ovf_q);
endmodule

// File: rtl/hash_cmd_front.sv
module hash_cmd_front
  import hash_fe_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          engine_done_i,
  input  logic          engine_ovf_i,
  output logic          start_o,
  output logic [1:0]    algo_o,
  output logic          accum_o,
  output logic          big_endian_o,
  output logic [DW-1:0] src_addr_o,
  output logic [DW-1:0] digest_addr_o,
  output logic [DW-1:0] key_addr_o,
  output logic [DW-1:0] length_o,
  output logic          irq_o
);
  logic [NUM_PTRS-1:0]    hit;
  logic [NUM_PTRS*DW-1:0] regs;
  logic [DW-1:0]          status, cmd_q;
  algo_e                  algo_dec, algo_q;
  logic                   legal, accept, cmd_wr, st_wr;

  assign cmd_wr = wr_en_i && (addr_i == AW'(OFS_CMD));
  assign st_wr  = wr_en_i && (addr_i == AW'(OFS_STATUS));

  hash_fe_ptrs #(.DW(DW), .AW(AW)) u_ptrs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .hit_o(hit), .regs_o(regs)
  );

  hash_fe_decode #(.DW(DW)) u_dec (
    .cmd_i(wdata_i), .algo_o(algo_dec), .legal_o(legal)
  );

  hash_fe_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_wr_i(cmd_wr), .legal_i(legal), .st_wr_i(st_wr), .wdata_i,
    .done_i(engine_done_i), .ovf_i(engine_ovf_i),
    .accept_o(accept), .start_o, .status_o(status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      algo_q <= ALG_SHA1;
    end else if (accept) begin
      cmd_q  <= wdata_i;
      algo_q <= algo_dec;
    end
  end

  assign algo_o        = algo_q;
  assign accum_o       = cmd_q[CMD_ACCUM];
  assign big_endian_o  = cmd_q[CMD_BE];
  assign src_addr_o    = regs[0*DW +: DW];
  assign digest_addr_o = regs[1*DW +: DW];
  assign key_addr_o    = regs[2*DW +: DW];
  assign length_o      = regs[3*DW +: DW];
  assign irq_o         = status[ST_IRQ];

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_STATUS)) rdata_o = status;
    if (addr_i == AW'(OFS_CMD))    rdata_o = cmd_q;
    for (int i = 0; i < NUM_PTRS; i++)
      if (hit[i]) rdata_o = regs[i*DW +: DW];
  end

  p_legal_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(cmd_wr && legal));
  p_hold_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> $stable(cmd_q));
endmodule

// File: tb/hash_cmd_front_test.sv
module hash_cmd_front_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, done = 0, ovf = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic start, accum, be, irq;
  logic [1:0] algo;
  logic [31:0] src, dig, key, len;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  hash_cmd_front uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .engine_done_i(done), .engine_ovf_i(ovf), .start_o(start),
    .algo_o(algo), .accum_o(accum), .big_endian_o(be), .src_addr_o(src),
    .digest_addr_o(dig), .key_addr_o(key), .length_o(len), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, last_cmd;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1
    rd(8'h1C, v); chk("R1 status", v, 0);
    rd(8'h30, v); chk("R1 cmd", v, 0);
    rd(8'h2C, v); chk("R1 len", v, 0);
    chk("R1 start", start, 0);

    // R2
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4 * i), 32'hA5000000 + 32'(i * 32'h111));
    for (int i = 0; i < 4; i++) begin
      rd(8'h20 + 8'(4 * i), v);
      chk("R2 readback", v, 32'hA5000000 + 32'(i * 32'h111));
    end
    chk("R2 src", src, 32'hA5000000);
    chk("R2 dig", dig, 32'hA5000111);
    chk("R2 key", key, 32'hA5000222);
    chk("R2 len", len, 32'hA5000333);

    // R7 done while idle
    pulse_done();
    rd(8'h1C, v); chk("R7 idle done", v, 0);

    last_cmd = 0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] c;
      logic lg;
      logic [1:0] ea;
      c = 0;
      c[10] = i[3]; c[6] = i[2]; c[5] = i[1]; c[4] = i[0];
      c[8] = i[0] ^ i[2]; c[3] = i[1] ^ i[3];
      c[31:24] = 8'(i * 7); c[1] = i[2];
      lg = 1; ea = 0;
      case (i)
        4'b0010: ea = 0;
        4'b0101: ea = 1;
        4'b1110: ea = 2;
        4'b0110: ea = 3;
        default: lg = 0;
      endcase
      wr(8'h30, c);
      if (lg) begin
        chk("R3 start", start, 1);
        rd(8'h1C, v); chk("R3 busy", v, 1);
        chk("R4 algo", algo, ea);
        chk("R4 accum", accum, c[8]);
        chk("R4 be", be, c[3]);
        rd(8'h30, v); chk("R3 cmd rb", v, c);
        last_cmd = c;
        @(negedge clk); chk("R3 pulse width", start, 0);
        // R6 second command while busy
        wr(8'h30, 32'h0000_0020);
        chk("R6 no start", start, 0);
        rd(8'h1C, v); chk("R6 ebusy", v, 32'h3);
        rd(8'h30, v); chk("R6 cmd kept", v, c);
        chk("R6 algo kept", algo, ea);
        pulse_done();
        rd(8'h1C, v); chk("R7 done", v, 32'h202);
        chk("R7 irq", irq, 1);
        // R8 partial clear, busy bit unwritable
        wr(8'h1C, 32'h0000_0201);
        rd(8'h1C, v); chk("R8 partial clr", v, 32'h2);
        wr(8'h1C, 32'h0000_0002);
        rd(8'h1C, v); chk("R8 clr ebusy", v, 0);
      end else begin
        chk("R5 no start", start, 0);
        rd(8'h1C, v); chk("R5 ealgo", v, 32'h4);
        rd(8'h30, v); chk("R5 cmd kept", v, last_cmd);
        wr(8'h1C, 32'h0000_0004);
        rd(8'h1C, v); chk("R8 clr ealgo", v, 0);
      end
    end

    // R9
    @(negedge clk); ovf = 1;
    @(negedge clk); ovf = 0;
    rd(8'h1C, v); chk("R9 ovf set", v, 32'h0080_0000);
    repeat (3) @(negedge clk);
    rd(8'h1C, v); chk("R9 ovf sticky", v, 32'h0080_0000);
    wr(8'h1C, 32'h0000_0200);
    rd(8'h1C, v); chk("R8 other bit kept", v, 32'h0080_0000);
    wr(8'h1C, 32'h0080_0000);
    rd(8'h1C, v); chk("R8 clr ovf", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule